// File: doc/BRIEF.md
# Floating-Point Branch Condition Evaluator

This block decides whether a floating-point conditional branch or conditional move should be taken. Each issued instruction presents a 4-bit condition code, a 2-bit selector naming which floating-point condition field to test, and the current contents of all condition fields. Each field is 2 bits and encodes the result of an earlier compare: 0 equal, 1 less, 2 greater, 3 unordered. The block answers with one registered `taken` bit, valid one clock later.

The low three condition bits pick one of eight base relations over the selected field. The top condition bit inverts that relation, which gives the complementary eight conditions. The design can be built with four fields or with a single field. With a single field, any selector value that names a field that does not exist is redirected to field 0.

A two-state machine tracks the output handshake. `ST_IDLE` means no result is being presented. `ST_RESULT` means `out_valid` is high and `taken` holds the answer for the instruction sampled on the previous edge. The machine has four transitions:
- `ST_IDLE` to `ST_RESULT` when `in_valid` is high.
- `ST_RESULT` to `ST_RESULT` for back-to-back issue.
- `ST_RESULT` to `ST_IDLE` when `in_valid` is low.
- `ST_IDLE` to `ST_IDLE` otherwise.

Top module: `fbr_cond_eval`

## Requirements
- R1: While reset is asserted and after it is released with no issue, `out_valid` and `taken` are both 0.
- R2: `out_valid` is 1 in exactly the cycle after each cycle in which `in_valid` was 1 at a rising edge, and 0 after any edge where `in_valid` was 0.
- R3: With condition bit 3 clear, base codes 0 to 3 give: 0 never taken; 1 taken when the field is not 0; 2 taken when the field is 1 or 2; 3 taken when the field is 1 or 3.
- R4: With condition bit 3 clear, base codes 4 to 7 give: 4 taken when the field is 1; 5 taken when the field is 2 or 3; 6 taken when the field is 2; 7 taken when the field is 3.
- R5: With condition bit 3 set, `taken` is the inverse of the base test named by bits 2:0. For example, code 8 is always taken and code 15 is taken unless the field is 3.
- R6: With four fields, field k occupies bits 2k+1:2k of `fields`, and selector value k tests field k only.
- R7: With a single field, every selector value tests bits 1:0 of `fields`.
- R8: When `in_valid` is 0, changes on `cond`, `sel` and `fields` have no effect: `taken` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction issue strobe; inputs sampled when high |
| cond | input | 4 | Condition code; bit 3 inverts the base relation in bits 2:0 |
| sel | input | 2 | Condition-field selector |
| fields | input | 2*NUM_FIELDS | Packed condition fields, field k at bits 2k+1:2k |
| out_valid | output | 1 | High for one cycle per sampled issue |
| taken | output | 1 | Branch/move decision, held between issues |

## Verification
Every decision is due exactly one rising edge after the cycle in which its issue strobe was sampled. The bench therefore drives each vector on a falling edge and reads `out_valid` and `taken` on the very next falling edge, before it drives the next vector. This gives one vector per cycle with issue held back-to-back. For the idle checks, the strobe is dropped and the inputs are changed. The outputs are then read one and two falling edges later, to confirm that `out_valid` has gone low and `taken` is unchanged.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    // Two-bit compare outcome held in each condition field
    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } fcc_rel_e;

    // Base relations selected by condition bits 2:0
    typedef enum logic [2:0] {
        BT_NEVER = 3'd0,
        BT_NE    = 3'd1,
        BT_LG    = 3'd2,
        BT_UL    = 3'd3,
        BT_L     = 3'd4,
        BT_UG    = 3'd5,
        BT_G     = 3'd6,
        BT_U     = 3'd7
    } base_test_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } handshake_state_e;

    localparam int unsigned FIELD_W = 2;
    localparam int unsigned SEL_W   = 2;
    localparam int unsigned COND_W  = 4;

endpackage

// File: rtl/fbr_field_mux.sv
module fbr_field_mux
    import fbr_pkg::*;
#(
    parameter int unsigned NUM_FIELDS = 4,
    localparam int unsigned FW        = FIELD_W * NUM_FIELDS
) (
    input  logic [FW-1:0]      fields,
    input  logic [SEL_W-1:0]   sel,
    output fcc_rel_e           field
);

    logic [FIELD_W-1:0] slot [NUM_FIELDS];
    logic [SEL_W-1:0]   idx;

    // Unpack the flat field vector into one slot per field
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_slot
        assign slot[g] = fields[g*FIELD_W +: FIELD_W];
    end

    // Selector values naming a field that is not built alias to field 0
    always_comb begin
        if (32'(sel) < NUM_FIELDS) idx = sel;
        else                       idx = '0;
    end

    always_comb begin
        field = REL_EQ;
        for (int k = 0; k < NUM_FIELDS; k++) begin
            if (idx == SEL_W'(k)) field = fcc_rel_e'(slot[k]);
        end
    end

endmodule

// File: rtl/fbr_base_test.sv
module fbr_base_test
    import fbr_pkg::*;
(
    input  base_test_e test,
    input  fcc_rel_e   rel,
    output logic       hit
);

    always_comb begin
        unique case (test)
            BT_NEVER: hit = 1'b0;
            BT_NE:    hit = (rel != REL_EQ);
            BT_LG:    hit = (rel == REL_LT) || (rel == REL_GT);
            BT_UL:    hit = (rel == REL_LT) || (rel == REL_UN);
            BT_L:     hit = (rel == REL_LT);
            BT_UG:    hit = (rel == REL_GT) || (rel == REL_UN);
            BT_G:     hit = (rel == REL_GT);
            BT_U:     hit = (rel == REL_UN);
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/fbr_cond_eval.sv
module fbr_cond_eval
    import fbr_pkg::*;
#(
    parameter int unsigned NUM_FIELDS = 4,
    localparam int unsigned FW        = FIELD_W * NUM_FIELDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        cond,
    input  logic [1:0]        sel,
    input  logic [FW-1:0]     fields,
    output logic              out_valid,
    output logic              taken
);

    handshake_state_e state_q, state_d;
    fcc_rel_e         rel;
    logic             base_hit;
    logic             decision;
    logic             taken_q;

    fbr_field_mux #(.NUM_FIELDS(NUM_FIELDS)) u_mux (
        .fields (fields),
        .sel    (sel),
        .field  (rel)
    );

    fbr_base_test u_base (
        .test (base_test_e'(cond[2:0])),
        .rel  (rel),
        .hit  (base_hit)
    );

    // Condition bit 3 turns each base relation into its complement
    assign decision = base_hit ^ cond[3];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Decision capture, only on an issue
    always_ff @(posedge clk) begin
        if (!rst_n)        taken_q <= 1'b0;
        else if (in_valid) taken_q <= decision;
    end

    // Outputs
    always_comb begin
        out_valid = (state_q == ST_RESULT);
        taken     = taken_q;
    end

endmodule

// File: rtl/fbr_cond_eval_chk.sv
module fbr_cond_eval_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [3:0] cond,
    input logic       out_valid,
    input logic       taken
);

    AST_VALID_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                   // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                 // R2
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(taken));                             // R8
    AST_NEVER_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond == 4'h0) |=> !taken);                    // R3
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond == 4'h8) |=> taken);                     // R5

endmodule

bind fbr_cond_eval fbr_cond_eval_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cond      (cond),
    .out_valid (out_valid),
    .taken     (taken)
);

// File: tb/sim_fbr_cond_eval.sv
module sim_fbr_cond_eval;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] cond = '0;
    logic [1:0] sel = '0;
    logic [7:0] fields4 = '0;
    logic       ov0, tk0, ov1, tk1;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          done     = 1'b0;

    always #5 clk = ~clk;

    fbr_cond_eval #(.NUM_FIELDS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond(cond),
        .sel(sel), .fields(fields4), .out_valid(ov0), .taken(tk0)
    );

    fbr_cond_eval #(.NUM_FIELDS(1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond(cond),
        .sel(sel), .fields(fields4[1:0]), .out_valid(ov1), .taken(tk1)
    );

    // Reference decision: arithmetic over field value 0 eq, 1 lt, 2 gt, 3 un
    function automatic logic ref_taken(input logic [3:0] c, input int unsigned f);
        logic b;
        case (c[2:0])
            3'd0: b = 1'b0;
            3'd1: b = (f != 0);
            3'd2: b = (f == 1) || (f == 2);
            3'd3: b = (f % 2) == 1;
            3'd4: b = (f == 1);
            3'd5: b = (f >= 2);
            3'd6: b = (f == 2);
            default: b = (f == 3);
        endcase
        return b ^ c[3];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b (cond=%h sel=%0d fields=%h)",
                     req, act, exp, cond, sel, fields4);
        end
    endtask

    function automatic string tag_for(input logic [3:0] c);
        if (c[3])      return "R5";
        else if (c[2]) return "R4";
        else           return "R3";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", ov0, 1'b0);
        check("R1 taken in reset", tk0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", ov0, 1'b0);
        check("R1 taken after reset", tk1, 1'b0);

        // Exhaustive sweep, one issue per cycle
        for (int c = 0; c < 16; c++) begin
            for (int s = 0; s < 4; s++) begin
                for (int f = 0; f < 256; f++) begin
                    logic [3:0] cc;
                    logic       e0, e1;
                    cc       = 4'(c);
                    in_valid = 1'b1;
                    cond     = cc;
                    sel      = 2'(s);
                    fields4  = 8'(f);
                    e0 = ref_taken(cc, (f >> (2*s)) & 3);
                    e1 = ref_taken(cc, f & 3);
                    @(negedge clk);
                    check("R2 out_valid", ov0, 1'b1);
                    check(s != 0 ? {tag_for(cc), "/R6"} : tag_for(cc), tk0, e0);
                    check({"R7/", tag_for(cc)}, tk1, e1);
                end
            end
        end

        // R8: inputs ignored while idle (taken held at 1)
        in_valid = 1'b1; cond = 4'h8; sel = 2'd0; fields4 = 8'h00;
        @(negedge clk);
        check("R5 always", tk0, 1'b1);
        in_valid = 1'b0; cond = 4'h0; sel = 2'd2; fields4 = 8'hFF;
        @(negedge clk);
        check("R2 valid drops", ov0, 1'b0);
        check("R8 held u0", tk0, 1'b1);
        fields4 = 8'h55; cond = 4'h7;
        @(negedge clk);
        check("R8 held u0 later", tk0, 1'b1);
        check("R8 held u1", tk1, 1'b1);

        // R8: taken held at 0
        in_valid = 1'b1; cond = 4'h0;
        @(negedge clk);
        check("R3 never", tk0, 1'b0);
        in_valid = 1'b0; cond = 4'h8;
        @(negedge clk);
        check("R8 held low u0", tk0, 1'b0);
        check("R8 held low u1", tk1, 1'b0);
        check("R2 no valid", ov1, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule